// File: doc/BRIEF.md
# Lane Write-Enable Mask Generator

This block turns an encoded lane-selection request into write strobes for a 512-bit accumulator register array. Each request is a 3-bit mode and a 7-bit count or index N, applied to a vector of 8, 16, 32 or 64 lanes. The lane count follows from a 2-bit element-size select. The mode chooses one of several mask shapes: all lanes, odd lanes or even lanes, a single lane, a leading run, or a trailing run. A run with N of zero means all lanes in one group of modes and no lanes in the other.

Two such requests are decoded side by side, one for the X axis and one for the Y axis. Each lane mask is also widened to 64 byte strobes by copying every lane bit across the bytes of its element. For matrix updates, the enable of Z element (j,i) is the product of Y lane j and X lane i. The block presents one Z row at a time: a row select picks Y lane j, and the output is the X byte strobes gated by that lane. All outputs are registered, so a request appears at the outputs one clock after it is presented.

Top module: `lmg_lane_write_enable`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: Lanes at or above the lane count (64 >> elem_sz; elem_sz 0,1,2,3 means 8,16,32,64-bit elements) are never enabled.
- R3: Mode 0 enables all lanes when N is 0, the odd lanes when N is 1, the even lanes when N is 2, and no lanes for any other N.
- R4: Mode 1 enables lane N alone, and enables nothing when N is not below the lane count.
- R5: Mode 2 enables lanes 0 to N-1, and enables every lane when N is 0 or N is at least the lane count.
- R6: Mode 3 enables the last N lanes, and enables every lane when N is 0 or N is at least the lane count.
- R7: Mode 4 enables lanes 0 to N-1, enables none when N is 0, and enables every lane when N is at least the lane count.
- R8: Mode 5 enables the last N lanes, enables none when N is 0, and enables every lane when N is at least the lane count.
- R9: Modes 6 and 7 enable no lanes.
- R10: Byte strobe b of an axis equals that axis's lane bit (b >> elem_sz).
- R11: z_row_byte_en equals x_byte_en when Y lane z_row is enabled, and is zero otherwise.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elem_sz | input | 2 | Element size select: 0=8, 1=16, 2=32, 3=64 bits |
| x_mode | input | 3 | X-axis mask mode |
| x_val | input | 7 | X-axis count or lane index N |
| y_mode | input | 3 | Y-axis mask mode |
| y_val | input | 7 | Y-axis count or lane index N |
| z_row | input | 6 | Y lane (Z row) whose byte strobes are reported |
| x_lane_en | output | 64 | X-axis lane enables |
| y_lane_en | output | 64 | Y-axis lane enables |
| x_byte_en | output | 64 | X-axis byte strobes |
| y_byte_en | output | 64 | Y-axis byte strobes |
| z_row_byte_en | output | 64 | Byte strobes of the selected Z row |

## Verification
The only state is one output register per port, so a wrong decode shows at the ports one clock after the bad request and stays there until the next request. Errors are most likely at N = 0, N = lane count - 1, N = lane count, and N above the lane count, and for suffix runs at every element size. These values are driven for every mode and size. A random stream follows, compared every cycle against a behavioural model. Gating by the Z row is checked with the row select both inside and outside the active lane range.

// File: rtl/lmg_pkg.sv
package lmg_pkg;
  localparam int unsigned LMG_LANES = 64;
  localparam int unsigned LMG_VAL_W = 7;

  typedef enum logic [2:0] {
    MODE_PARITY   = 3'd0,
    MODE_SINGLE   = 3'd1,
    MODE_HEAD_ALL = 3'd2,
    MODE_TAIL_ALL = 3'd3,
    MODE_HEAD     = 3'd4,
    MODE_TAIL     = 3'd5
  } mask_mode_e;
endpackage

// File: rtl/lmg_lane_mask.sv
module lmg_lane_mask #(
  parameter int unsigned LANES = 64,
  parameter int unsigned VAL_W = 7,
  parameter int unsigned SZ_W  = 2
) (
  input  logic [2:0]       mode,
  input  logic [VAL_W-1:0] val,
  input  logic [SZ_W-1:0]  sz,
  output logic [LANES-1:0] lanes
);
  import lmg_pkg::*;

  localparam int unsigned LOG = $clog2(LANES);
  localparam int unsigned CW  = (VAL_W > LOG + 1) ? VAL_W + 1 : LOG + 2;

  logic [CW-1:0] lane_cnt;
  logic [CW-1:0] n_ext;
  logic [CW-1:0] tail_start;
  logic          n_zero;
  logic          n_sat;

  always_comb begin
    lane_cnt   = CW'(LANES) >> sz;
    n_ext      = CW'(val);
    n_zero     = (val == '0);
    n_sat      = (n_ext >= lane_cnt);
    tail_start = n_sat ? '0 : (lane_cnt - n_ext);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CW-1:0] IDX = CW'(i);
    logic on_b;
    logic in_rng;

    always_comb begin
      in_rng = (IDX < lane_cnt);
      case (mode)
        MODE_PARITY: begin
          if (n_ext == CW'(0))      on_b = 1'b1;
          else if (n_ext == CW'(1)) on_b = IDX[0];
          else if (n_ext == CW'(2)) on_b = ~IDX[0];
          else                      on_b = 1'b0;
        end
        MODE_SINGLE:   on_b = (n_ext == IDX);
        MODE_HEAD_ALL: on_b = n_zero | n_sat | (IDX < n_ext);
        MODE_TAIL_ALL: on_b = n_zero | (IDX >= tail_start);
        MODE_HEAD:     on_b = n_sat | (IDX < n_ext);
        MODE_TAIL:     on_b = ~n_zero & (IDX >= tail_start);
        default:       on_b = 1'b0;
      endcase
    end

    assign lanes[i] = on_b & in_rng;
  end
endmodule

// File: rtl/lmg_byte_expand.sv
module lmg_byte_expand #(
  parameter int unsigned LANES = 64,
  parameter int unsigned SZ_W  = 2
) (
  input  logic [LANES-1:0] lanes,
  input  logic [SZ_W-1:0]  sz,
  output logic [LANES-1:0] bytes_en
);
  localparam int unsigned LOG = $clog2(LANES);

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    localparam logic [LOG-1:0] BIDX = LOG'(b);
    logic [LOG-1:0] src;
    assign src         = BIDX >> sz;
    assign bytes_en[b] = lanes[src];
  end
endmodule

// File: rtl/lmg_lane_write_enable.sv
module lmg_lane_write_enable #(
  parameter int unsigned LANES = lmg_pkg::LMG_LANES,
  parameter int unsigned VAL_W = lmg_pkg::LMG_VAL_W,
  parameter int unsigned SZ_W  = 2,
  parameter int unsigned ROW_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SZ_W-1:0]  elem_sz,
  input  logic [2:0]       x_mode,
  input  logic [VAL_W-1:0] x_val,
  input  logic [2:0]       y_mode,
  input  logic [VAL_W-1:0] y_val,
  input  logic [ROW_W-1:0] z_row,
  output logic [LANES-1:0] x_lane_en,
  output logic [LANES-1:0] y_lane_en,
  output logic [LANES-1:0] x_byte_en,
  output logic [LANES-1:0] y_byte_en,
  output logic [LANES-1:0] z_row_byte_en
);
  localparam int unsigned AXES = 2;

  logic [2:0]       ax_mode [AXES];
  logic [VAL_W-1:0] ax_val  [AXES];
  logic [LANES-1:0] ax_lane [AXES];
  logic [LANES-1:0] ax_byte [AXES];
  logic [LANES-1:0] z_next;
  logic             upd_en;

  assign ax_mode[0] = x_mode;
  assign ax_val[0]  = x_val;
  assign ax_mode[1] = y_mode;
  assign ax_val[1]  = y_val;
  assign upd_en     = 1'b1;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    lmg_lane_mask #(.LANES(LANES), .VAL_W(VAL_W), .SZ_W(SZ_W)) u_mask (
      .mode (ax_mode[a]),
      .val  (ax_val[a]),
      .sz   (elem_sz),
      .lanes(ax_lane[a])
    );
    lmg_byte_expand #(.LANES(LANES), .SZ_W(SZ_W)) u_expand (
      .lanes   (ax_lane[a]),
      .sz      (elem_sz),
      .bytes_en(ax_byte[a])
    );
  end

  always_comb begin
    z_next = ax_lane[1][z_row] ? ax_byte[0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_lane_en     <= '0;
      y_lane_en     <= '0;
      x_byte_en     <= '0;
      y_byte_en     <= '0;
      z_row_byte_en <= '0;
    end else if (upd_en) begin
      x_lane_en     <= ax_lane[0];
      y_lane_en     <= ax_lane[1];
      x_byte_en     <= ax_byte[0];
      y_byte_en     <= ax_byte[1];
      z_row_byte_en <= z_next;
    end
  end
endmodule

// File: rtl/lmg_lane_write_enable_chk.sv
module lmg_lane_write_enable_chk #(
  parameter int unsigned LANES = 64,
  parameter int unsigned VAL_W = 7,
  parameter int unsigned SZ_W  = 2,
  parameter int unsigned ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SZ_W-1:0]  elem_sz,
  input logic [2:0]       x_mode,
  input logic [2:0]       y_mode,
  input logic [LANES-1:0] x_lane_en,
  input logic [LANES-1:0] y_lane_en,
  input logic [LANES-1:0] x_byte_en,
  input logic [LANES-1:0] y_byte_en,
  input logic [LANES-1:0] z_row_byte_en
);
  logic [SZ_W-1:0] sz_q;
  logic [LANES:0]  valid_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sz_q <= '0;
    else        sz_q <= elem_sz;
  end

  assign valid_mask = ~({(LANES+1){1'b1}} << ((LANES+1)'(LANES) >> sz_q));

  assert_upper_lanes_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_lane_en | y_lane_en) & ~valid_mask[LANES-1:0]) == '0);

  assert_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (x_mode == 3'd1) |=> ($countones(x_lane_en) <= 1));

  assert_idle_modes_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_mode[2:1] == 2'b11) |=> (x_lane_en == '0));

  assert_idle_modes_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (y_mode[2:1] == 2'b11) |=> (y_lane_en == '0));

  assert_zrow_subset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (z_row_byte_en & ~x_byte_en) == '0);

  assert_zrow_needs_y_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (z_row_byte_en != '0) |-> (y_lane_en != '0));

  for (genvar b = 0; b < LANES; b++) begin : g_bchk
    assert_byte_follows_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (x_byte_en[b] == x_lane_en[b >> sz_q]) && (y_byte_en[b] == y_lane_en[b >> sz_q]));
  end
endmodule

bind lmg_lane_write_enable lmg_lane_write_enable_chk #(
  .LANES(LANES), .VAL_W(VAL_W), .SZ_W(SZ_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .elem_sz(elem_sz), .x_mode(x_mode), .y_mode(y_mode),
  .x_lane_en(x_lane_en), .y_lane_en(y_lane_en), .x_byte_en(x_byte_en),
  .y_byte_en(y_byte_en), .z_row_byte_en(z_row_byte_en)
);

// File: tb/lmg_lane_write_enable_tb.sv
`timescale 1ns/1ps
module lmg_lane_write_enable_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  elem_sz;
  logic [2:0]  x_mode, y_mode;
  logic [6:0]  x_val, y_val;
  logic [5:0]  z_row;
  logic [63:0] x_lane_en, y_lane_en, x_byte_en, y_byte_en, z_row_byte_en;

  int checks;
  int failures;

  lmg_lane_write_enable dut_i (
    .clk(clk), .rst_n(rst_n), .elem_sz(elem_sz),
    .x_mode(x_mode), .x_val(x_val), .y_mode(y_mode), .y_val(y_val), .z_row(z_row),
    .x_lane_en(x_lane_en), .y_lane_en(y_lane_en), .x_byte_en(x_byte_en),
    .y_byte_en(y_byte_en), .z_row_byte_en(z_row_byte_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_lanes(int mode, int n, int sz);
    int cnt;
    logic [63:0] m;
    cnt = 64 >> sz;
    m = '0;
    for (int i = 0; i < cnt; i++) begin
      bit on;
      case (mode)
        0: on = (n == 0) || (n == 1 && (i % 2) == 1) || (n == 2 && (i % 2) == 0);
        1: on = (i == n);
        2: on = (n == 0) || (i < n);
        3: on = (n == 0) || (i >= cnt - n);
        4: on = (i < n);
        5: on = (n > 0) && (i >= cnt - n);
        default: on = 0;
      endcase
      m[i] = on;
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_bytes(logic [63:0] l, int sz);
    logic [63:0] m;
    for (int b = 0; b < 64; b++) m[b] = l[b >> sz];
    return m;
  endfunction

  function automatic string mode_req(int mode);
    case (mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected values from the request driven in the previous cycle (R12)
  logic [63:0] e_xl, e_yl, e_xb, e_yb, e_z, e_valid;
  int p_xm, p_ym;
  bit have_prev;

  task automatic drive(int sz, int xm, int xv, int ym, int yv, int row);
    @(negedge clk);
    if (have_prev) begin
      // R12: outputs now hold the request sampled at the edge just passed
      check(mode_req(p_xm), x_lane_en, e_xl);
      check(mode_req(p_ym), y_lane_en, e_yl);
      check("R2", (x_lane_en | y_lane_en) & ~e_valid, 64'h0);
      check("R10", x_byte_en, e_xb);
      check("R10", y_byte_en, e_yb);
      check("R11", z_row_byte_en, e_z);
    end
    elem_sz = 2'(sz); x_mode = 3'(xm); x_val = 7'(xv);
    y_mode = 3'(ym); y_val = 7'(yv); z_row = 6'(row);
    e_xl = ref_lanes(xm, xv, sz);
    e_yl = ref_lanes(ym, yv, sz);
    e_xb = ref_bytes(e_xl, sz);
    e_yb = ref_bytes(e_yl, sz);
    e_z  = e_yl[row] ? e_xb : 64'h0;
    e_valid = (sz == 0) ? '1 : ((64'h1 << (64 >> sz)) - 64'h1);
    p_xm = xm; p_ym = ym;
    have_prev = 1;
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int vals[9];
    checks = 0; failures = 0; have_prev = 0;
    rst_n = 1'b0;
    elem_sz = 2'd0; x_mode = 3'd0; x_val = 7'd0; y_mode = 3'd0; y_val = 7'd0; z_row = 6'd0;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs low even with an all-lanes request present
    check("R1", x_lane_en | y_lane_en, 64'h0);
    check("R1", x_byte_en | y_byte_en | z_row_byte_en, 64'h0);
    rst_n = 1'b1;

    for (int sz = 0; sz < 4; sz++) begin
      int cnt;
      cnt = 64 >> sz;
      vals = '{0, 1, 2, 3, cnt - 1, cnt, cnt + 1, 127, 5};
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < 9; k++)
          drive(sz, m, vals[k], 7 - m, vals[8 - k], (k * 7 + m) % 64);
    end
    for (int t = 0; t < 3000; t++)
      drive($urandom_range(3), $urandom_range(7), $urandom_range(70),
            $urandom_range(7), $urandom_range(70), $urandom_range(63));
    drive(0, 6, 0, 7, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule